// File: doc/BRIEF.md
# Segment Privilege Check Unit

This block judges whether a protected-mode operation may proceed, using only privilege levels. Each request carries the current level of the running code, the requested level taken from a selector, the level of the target descriptor, the level of a call gate, the I/O level from the flags register and a 3-bit operation class. The operation class names both the kind of descriptor being used and the kind of instruction. Privilege levels are 2-bit numbers. Level 0 has the most rights and level 3 the fewest.

One cycle after a request strobe the block presents a registered verdict. The verdict is either an allow pulse or a general-protection fault pulse. A fault pulse comes with a 3-bit code that names the rule that failed. The verdict also carries the privilege level the code will run at afterwards. For a flag-restore request it also carries a mask of the flag bits that the restore may write. Fetching descriptors and checking segment limits are done elsewhere.

Operation class encoding on `op_class`: 0 data segment load, 1 stack segment load, 2 transfer to conforming code, 3 direct transfer to non-conforming code, 4 call through a gate, 5 system instruction, 6 interrupt-flag or port I/O instruction, 7 flag restore.

Top module: `seg_priv_check`

## Requirements
- R1: While reset is held, or in any cycle after a cycle with `req_valid` low, `done`, `allow`, `fault`, `fault_code`, `flag_mask` and `next_cpl` are all zero. A request sampled at a rising edge raises `done` for exactly the following cycle.
- R2: A data segment load (class 0) is allowed only when the larger of `rpl` and `cpl` is less than or equal to `dpl`. If it fails, the fault code is 1.
- R3: A stack segment load (class 1) is allowed only when `dpl` equals `cpl`. If it fails, the fault code is 2.
- R4: A transfer to conforming code (class 2) is allowed only when `dpl` is less than or equal to `cpl`. If it fails, the fault code is 3. When it is allowed, `next_cpl` equals `cpl`.
- R5: A direct transfer to non-conforming code (class 3) is allowed only when `dpl` equals `cpl` and `rpl` is less than or equal to `cpl`. If it fails, the fault code is 4.
- R6: A call through a gate (class 4) is allowed only when `dpl` is less than or equal to the larger of `rpl` and `cpl`, and that larger value is less than or equal to `gate_dpl`. If it fails, the fault code is 5. When it is allowed, `next_cpl` equals `dpl`.
- R7: A system instruction (class 5) is allowed only when `cpl` is 0. If it fails, the fault code is 6.
- R8: An interrupt-flag or port I/O instruction (class 6) is allowed only when `cpl` is less than or equal to `iopl`. If it fails, the fault code is 7.
- R9: A flag restore (class 7) is always allowed. When `cpl` is 0, `flag_mask` is all ones. When `cpl` is above 0, `flag_mask` is zero at bit 9 (interrupt enable) and at bits 13:12 (I/O level) and one everywhere else. For every other class, `flag_mask` is zero.
- R10: When `done` is high, exactly one of `allow` and `fault` is high. `fault_code` is nonzero exactly when `fault` is high.
- R11: In every result cycle, `next_cpl` equals the request's `cpl`. The only exception is an allowed gate call (R6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe; operands are sampled on the same edge |
| op_class | input | 3 | Operation class, encoded as listed above |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Requested privilege level from the selector |
| dpl | input | 2 | Target descriptor privilege level |
| gate_dpl | input | 2 | Call gate privilege level |
| iopl | input | 2 | I/O privilege level |
| done | output | 1 | High for one cycle with each verdict |
| allow | output | 1 | Request allowed |
| fault | output | 1 | General-protection fault pulse |
| fault_code | output | 3 | Failed rule (1 to 7), 0 when no fault |
| flag_mask | output | FLAG_W | Flag bits a restore may write |
| next_cpl | output | 2 | Privilege level after the operation |

## Verification
A fault verdict and a flag-mask verdict can land in adjacent cycles when strobes arrive back to back. In that case the fault pulse has to fall in the same cycle that the mask appears. The bench provokes this with a directed pair: a failing system instruction at level 3, followed by a flag restore at level 3 on the very next edge. It also mixes random gaps of zero or one cycle between random requests. In every result cycle it compares all outputs, including the cleared `fault` and `fault_code`, against values computed from the rules.

// File: rtl/seg_priv_pkg.sv
// Shared types for the segment privilege check unit.
// Assumes 2-bit privilege levels where a smaller number means more rights.
package seg_priv_pkg;

    localparam int PRIV_W = 2;

    typedef logic [PRIV_W-1:0] priv_t;

    typedef enum logic [2:0] {
        OP_DATA_LOAD    = 3'd0,
        OP_STACK_LOAD   = 3'd1,
        OP_CONFORM      = 3'd2,
        OP_NONCONF      = 3'd3,
        OP_GATE_CALL    = 3'd4,
        OP_SYS_INSTR    = 3'd5,
        OP_PORT_IO      = 3'd6,
        OP_FLAG_RESTORE = 3'd7
    } op_class_e;

    typedef enum logic [2:0] {
        FC_NONE    = 3'd0,
        FC_DATA    = 3'd1,
        FC_STACK   = 3'd2,
        FC_CONFORM = 3'd3,
        FC_NONCONF = 3'd4,
        FC_GATE    = 3'd5,
        FC_SYS     = 3'd6,
        FC_PORT    = 3'd7
    } fault_code_e;

    // Effective level: the numerically larger (less privileged) of the two.
    function automatic priv_t eff_priv(input priv_t a, input priv_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_priv_rules.sv
// Combinational rule evaluation for one request.
// Every rule is evaluated in parallel and the operation class selects one.
// Assumes all inputs are stable around the sampling edge; it holds no state.
module seg_priv_rules
    import seg_priv_pkg::*;
(
    input  op_class_e   op,
    input  priv_t       cpl,
    input  priv_t       rpl,
    input  priv_t       dpl,
    input  priv_t       gate_dpl,
    input  priv_t       iopl,
    output logic        pass,
    output fault_code_e code,
    output priv_t       ncpl
);

    localparam int NUM_OPS = 8;

    priv_t              eff;
    logic [NUM_OPS-1:0] rule_ok;

    assign eff = eff_priv(rpl, cpl);

    // Evaluate every rule against the operands.
    always_comb begin
        rule_ok                  = '0;
        rule_ok[OP_DATA_LOAD]    = (eff <= dpl);
        rule_ok[OP_STACK_LOAD]   = (dpl == cpl);
        rule_ok[OP_CONFORM]      = (dpl <= cpl);
        rule_ok[OP_NONCONF]      = (dpl == cpl) && (rpl <= cpl);
        rule_ok[OP_GATE_CALL]    = (dpl <= eff) && (eff <= gate_dpl);
        rule_ok[OP_SYS_INSTR]    = (cpl == '0);
        rule_ok[OP_PORT_IO]      = (cpl <= iopl);
        rule_ok[OP_FLAG_RESTORE] = 1'b1;
    end

    assign pass = rule_ok[op];

    // Name the rule that failed, or report none.
    always_comb begin
        code = FC_NONE;
        if (!pass) begin
            unique case (op)
                OP_DATA_LOAD:  code = FC_DATA;
                OP_STACK_LOAD: code = FC_STACK;
                OP_CONFORM:    code = FC_CONFORM;
                OP_NONCONF:    code = FC_NONCONF;
                OP_GATE_CALL:  code = FC_GATE;
                OP_SYS_INSTR:  code = FC_SYS;
                OP_PORT_IO:    code = FC_PORT;
                default:       code = FC_NONE;
            endcase
        end
    end

    // Only a successful gate call changes the running level.
    assign ncpl = (op == OP_GATE_CALL && pass) ? dpl : cpl;

endmodule

// File: rtl/seg_priv_flagmask.sv
// Builds the mask of flag bits that a flag restore may write.
// Below level 0, the interrupt-enable bit and the I/O level field are locked.
// Assumes IOPL_LSB+1 and IF_BIT both lie inside FLAG_W.
module seg_priv_flagmask
    import seg_priv_pkg::*;
#(
    parameter int FLAG_W   = 32,
    parameter int IF_BIT   = 9,
    parameter int IOPL_LSB = 12
) (
    input  logic              is_restore,
    input  priv_t             cpl,
    output logic [FLAG_W-1:0] mask
);

    logic at_top;
    assign at_top = (cpl == '0);

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        localparam bit LOCKED = (i == IF_BIT) || (i == IOPL_LSB) || (i == IOPL_LSB + 1);
        if (LOCKED) begin : g_locked
            assign mask[i] = is_restore && at_top;
        end else begin : g_free
            assign mask[i] = is_restore;
        end
    end

endmodule

// File: rtl/seg_priv_result_reg.sv
// Output stage that registers one verdict per request strobe.
// With no strobe, every output returns to zero on the next edge.
module seg_priv_result_reg
    import seg_priv_pkg::*;
#(
    parameter int FLAG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              pass,
    input  fault_code_e       code_in,
    input  priv_t             ncpl_in,
    input  logic [FLAG_W-1:0] mask_in,
    output logic              done,
    output logic              allow,
    output logic              fault,
    output logic [2:0]        fault_code,
    output logic [FLAG_W-1:0] flag_mask,
    output priv_t             next_cpl
);

    // Capture the verdict on a strobe and clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            allow      <= 1'b0;
            fault      <= 1'b0;
            fault_code <= '0;
            flag_mask  <= '0;
            next_cpl   <= '0;
        end else begin
            done       <= req_valid;
            allow      <= req_valid && pass;
            fault      <= req_valid && !pass;
            fault_code <= req_valid ? code_in : FC_NONE;
            flag_mask  <= req_valid ? mask_in : '0;
            next_cpl   <= req_valid ? ncpl_in : '0;
        end
    end

endmodule

// File: rtl/seg_priv_check.sv
// Top level of the segment privilege check unit.
// Evaluates the privilege rules for the strobed request and registers the
// verdict, fault code, next level and flag-restore mask one cycle later.
// Assumes the operands are valid on every edge where req_valid is high.
module seg_priv_check
    import seg_priv_pkg::*;
#(
    parameter int FLAG_W   = 32,
    parameter int IF_BIT   = 9,
    parameter int IOPL_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        op_class,
    input  logic [1:0]        cpl,
    input  logic [1:0]        rpl,
    input  logic [1:0]        dpl,
    input  logic [1:0]        gate_dpl,
    input  logic [1:0]        iopl,
    output logic              done,
    output logic              allow,
    output logic              fault,
    output logic [2:0]        fault_code,
    output logic [FLAG_W-1:0] flag_mask,
    output logic [1:0]        next_cpl
);

    op_class_e         op;
    logic              pass;
    fault_code_e       code;
    priv_t             ncpl;
    logic [FLAG_W-1:0] mask;

    assign op = op_class_e'(op_class);

    seg_priv_rules u_rules (
        .op       (op),
        .cpl      (cpl),
        .rpl      (rpl),
        .dpl      (dpl),
        .gate_dpl (gate_dpl),
        .iopl     (iopl),
        .pass     (pass),
        .code     (code),
        .ncpl     (ncpl)
    );

    seg_priv_flagmask #(
        .FLAG_W   (FLAG_W),
        .IF_BIT   (IF_BIT),
        .IOPL_LSB (IOPL_LSB)
    ) u_mask (
        .is_restore (op == OP_FLAG_RESTORE),
        .cpl        (cpl),
        .mask       (mask)
    );

    seg_priv_result_reg #(
        .FLAG_W (FLAG_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .pass       (pass),
        .code_in    (code),
        .ncpl_in    (ncpl),
        .mask_in    (mask),
        .done       (done),
        .allow      (allow),
        .fault      (fault),
        .fault_code (fault_code),
        .flag_mask  (flag_mask),
        .next_cpl   (next_cpl)
    );

endmodule

// File: rtl/seg_priv_check_sva.sv
// Property checker for seg_priv_check, attached through bind.
// Relates the strobed request operands to the verdict one cycle later.
module seg_priv_check_sva #(
    parameter int FLAG_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        op_class,
    input logic [1:0]        cpl,
    input logic [1:0]        rpl,
    input logic [1:0]        dpl,
    input logic [1:0]        gate_dpl,
    input logic [1:0]        iopl,
    input logic              done,
    input logic              allow,
    input logic              fault,
    input logic [2:0]        fault_code,
    input logic [FLAG_W-1:0] flag_mask,
    input logic [1:0]        next_cpl
);

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!done && !allow && !fault && fault_code == 3'd0 && flag_mask == '0));

    p_stack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_class == 3'd1) |=> (allow == $past(dpl == cpl)));

    p_sys_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_class == 3'd5 && cpl != 2'd0) |=> (fault && fault_code == 3'd6));

    p_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_class == 3'd6 && cpl <= iopl) |=> allow);

    p_mask_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_class != 3'd7) |=> (flag_mask == '0));

    p_mask_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_class == 3'd7 && cpl == 2'd0) |=> (&flag_mask && allow));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (allow != fault));

    p_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault == (fault_code != 3'd0));

    p_gate_cpl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_class == 3'd4) |=> (!allow || next_cpl == $past(dpl)));

endmodule

bind seg_priv_check seg_priv_check_sva #(.FLAG_W(FLAG_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .op_class   (op_class),
    .cpl        (cpl),
    .rpl        (rpl),
    .dpl        (dpl),
    .gate_dpl   (gate_dpl),
    .iopl       (iopl),
    .done       (done),
    .allow      (allow),
    .fault      (fault),
    .fault_code (fault_code),
    .flag_mask  (flag_mask),
    .next_cpl   (next_cpl)
);

// File: tb/seg_priv_check_tb.sv
// Self-checking bench: directed corners plus seeded random requests with
// random gaps, compared against a rule model written from the requirements.
module seg_priv_check_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FLAG_W     = 32;
    localparam int N_RANDOM   = 3000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        op_class = '0;
    logic [1:0]        cpl = '0, rpl = '0, dpl = '0, gate_dpl = '0, iopl = '0;
    logic              done, allow, fault;
    logic [2:0]        fault_code;
    logic [FLAG_W-1:0] flag_mask;
    logic [1:0]        next_cpl;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Expected result of the request issued one cycle earlier.
    bit                have_prev = 1'b0;
    logic [2:0]        p_op;
    bit                p_allow;
    logic [2:0]        p_code;
    logic [FLAG_W-1:0] p_mask;
    logic [1:0]        p_ncpl;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_priv_check u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .op_class   (op_class),
        .cpl        (cpl),
        .rpl        (rpl),
        .dpl        (dpl),
        .gate_dpl   (gate_dpl),
        .iopl       (iopl),
        .done       (done),
        .allow      (allow),
        .fault      (fault),
        .fault_code (fault_code),
        .flag_mask  (flag_mask),
        .next_cpl   (next_cpl)
    );

    function automatic logic [1:0] larger(input logic [1:0] a, input logic [1:0] b);
        return (a >= b) ? a : b;
    endfunction

    function automatic bit model_allow(input logic [2:0] op, input logic [1:0] c, r, d, g, io);
        case (op)
            3'd0: return larger(r, c) <= d;                       // R2
            3'd1: return d == c;                                  // R3
            3'd2: return d <= c;                                  // R4
            3'd3: return (d == c) && (r <= c);                    // R5
            3'd4: return (d <= larger(r, c)) && (larger(r, c) <= g); // R6
            3'd5: return c == 2'd0;                               // R7
            3'd6: return c <= io;                                 // R8
            default: return 1'b1;                                 // R9
        endcase
    endfunction

    function automatic logic [FLAG_W-1:0] model_mask(input logic [2:0] op, input logic [1:0] c);
        if (op != 3'd7) return '0;
        if (c == 2'd0) return '1;
        return 32'hFFFF_CDFF;
    endfunction

    function automatic string rule_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R2 data load";
            3'd1: return "R3 stack load";
            3'd2: return "R4 conforming";
            3'd3: return "R5 non-conforming";
            3'd4: return "R6 gate call";
            3'd5: return "R7 system instruction";
            3'd6: return "R8 port io";
            default: return "R9 flag restore";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: check the previous cycle's result, then drive the next request.
    task automatic step(input bit issue, input logic [2:0] op, input logic [1:0] c, r, d, g, io);
        @(negedge clk);
        if (have_prev) begin
            chk("R1 done after strobe", {31'd0, done}, 32'd1);
            chk({rule_tag(p_op), " allow"}, {31'd0, allow}, {31'd0, p_allow});
            chk("R10 fault pulse", {31'd0, fault}, {31'd0, !p_allow});
            chk({rule_tag(p_op), " R10 fault code"}, {29'd0, fault_code}, {29'd0, p_code});
            chk("R9 flag mask", flag_mask, p_mask);
            chk("R11 next level", {30'd0, next_cpl}, {30'd0, p_ncpl});
        end else begin
            chk("R1 idle outputs", {done, allow, fault, fault_code, next_cpl},  32'd0);
            chk("R1 idle mask", flag_mask, 32'd0);
        end
        req_valid = issue;
        op_class = op; cpl = c; rpl = r; dpl = d; gate_dpl = g; iopl = io;
        have_prev = issue;
        if (issue) begin
            p_op    = op;
            p_allow = model_allow(op, c, r, d, g, io);
            p_code  = p_allow ? 3'd0 : op + 3'd1;
            p_mask  = model_mask(op, c);
            p_ncpl  = (op == 3'd4 && p_allow) ? d : c;   // R6 / R11
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset done", {31'd0, done}, 32'd0);
        chk("R1 reset fault", {31'd0, fault}, 32'd0);
        chk("R1 reset mask", flag_mask, 32'd0);
        rst_n = 1'b1;

        // Directed corners.
        step(1, 3'd0, 2'd0, 2'd3, 2'd2, 2'd0, 2'd0); // R2: weak selector level fails
        step(1, 3'd0, 2'd2, 2'd1, 2'd2, 2'd0, 2'd0); // R2: equal levels pass
        step(1, 3'd1, 2'd1, 2'd0, 2'd2, 2'd0, 2'd0); // R3: mismatch fails
        step(1, 3'd2, 2'd2, 2'd0, 2'd1, 2'd0, 2'd0); // R4: more privileged target passes
        step(1, 3'd2, 2'd2, 2'd0, 2'd3, 2'd0, 2'd0); // R4: less privileged target fails
        step(1, 3'd3, 2'd1, 2'd2, 2'd1, 2'd0, 2'd0); // R5: rpl above cpl fails
        step(1, 3'd4, 2'd2, 2'd0, 2'd0, 2'd2, 2'd0); // R6: level 2 through gate 2 to 0
        step(1, 3'd4, 2'd2, 2'd0, 2'd0, 2'd1, 2'd0); // R6: gate too privileged fails
        step(1, 3'd5, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0); // R7: level 0 passes
        step(1, 3'd6, 2'd2, 2'd0, 2'd0, 2'd0, 2'd2); // R8: cpl equals iopl passes
        step(1, 3'd7, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0); // R9: full mask
        step(0, 3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0);
        // Fault followed at once by a restore: fault must clear as mask appears (R10, R9).
        step(1, 3'd5, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0);
        step(1, 3'd7, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0);
        step(0, 3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0);

        for (int i = 0; i < N_RANDOM; i++) begin
            bit issue;
            issue = ($urandom % 4) != 0;
            step(issue, 3'($urandom), 2'($urandom), 2'($urandom),
                 2'($urandom), 2'($urandom), 2'($urandom));
        end
        step(0, 3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0);
        step(0, 3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule